// File: doc/BRIEF.md
# Serial Second-Order IIR Filter

This block is a second-order recursive filter in direct form II. It uses one shared multiplier and one shared adder. The multiplier needs two cycles for each product and the adder needs one. Both are driven from a fixed schedule of 11 clock cycles. That schedule repeats for every input sample, and successive samples never overlap. A free-running slot counter drives the operand multiplexers, the register enables and the coefficient lookup. Partial results are held in a small set of scratch registers, and the filter state is held in three state registers.

The host places one signed sample on the input for every 11 clocks. Each new output appears one clock after the last slot of an iteration and is marked by a valid strobe that lasts one cycle. The feedback sign is folded into the recursive coefficients, so every combining step is an addition. Each product is brought back to the data format by an arithmetic right shift of the coefficient's fractional bits. The low data bits of the shifted product are kept. Sums wrap in two's complement.

Top module: `serial_biquad`

## Requirements
- R1: While rst_ni is low, y_o and y_valid_o are 0. Reset clears all state and scratch registers and returns the slot counter to slot 0. The first output after reset is therefore mulq(b0, x0).
- R2: One iteration lasts 11 clocks, slots 0 to 10. y_valid_o is high for exactly one clock per iteration. That clock is the one after the rising edge that ends slot 10. The first such rising edge after reset release is the 11th.
- R3: mulq(c, v) means the full signed product c·v, arithmetically shifted right by FRAC bits (rounding toward minus infinity), with its low DW bits kept. For example, mulq(8192, -3) = -2 when FRAC = 14.
- R4: The new state is w = x + (mulq(a2,d2) + mulq(a1,d1)). The inner sum is formed first, and every sum wraps at DW bits.
- R5: The output is y = mulq(b0,w) + (mulq(b2,d2) + mulq(b1,d1)), with every sum wrapping at DW bits.
- R6: At the edge that ends slot 10, d1 takes w and d2 takes the old d1. Neither changes at any other edge.
- R7: sample_i is captured only at the edge that ends slot 0. Its value at every other edge of the iteration has no effect on y_o.
- R8: y_o changes only at the edge that ends slot 10, and holds its value through the rest of the next iteration.
- R9: The multiplier starts a product in every even slot from 0 to 8, and never in two consecutive slots. The coefficients are used in the order a2, a1, b2, b1, b0. Their partners are d2, d1, d2, d1 and w.
- R10: With the default coefficients (a high-pass response), a tone at fs/64 comes out with a peak at least 8 times smaller than a tone of equal amplitude at fs/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DW | Signed input sample, captured in slot 0 |
| y_o | output | DW | Signed filtered output |
| y_valid_o | output | 1 | Single-cycle strobe when y_o is updated |

## Verification
Two events land on the same edge at the end of slot 10: the output sum is registered, and the state delays shift. The output sum must still be built from the delays as they stood before that shift. A unit impulse followed by zeros makes this visible, because the response in the second and third iterations is nonzero only if the old d1 and d2 were read and the new values were stored after them. A step and full-scale extremes push the same collision through wrapped sums. Each output is judged against a bench model that applies the truncation and wrap rules stated in R3 to R5.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned PERIOD = 11;
  localparam int unsigned CNT_W  = $clog2(PERIOD);

  typedef enum logic [1:0] {SRC_D2, SRC_D1, SRC_W} mul_src_e;
  typedef enum logic [1:0] {ADD_NONE, ADD_PSUM, ADD_STATE, ADD_OUT} add_op_e;

  typedef struct packed {
    logic      mul_issue;
    mul_src_e  mul_src;
    logic [2:0] rom_idx;
    logic      wr_r2;
    logic      wr_r3;
    add_op_e   add_op;
    logic      x_load;
    logic      shift;
  } ctrl_t;
endpackage

// File: rtl/biquad_seq.sv
module biquad_seq
  import biquad_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output ctrl_t ctrl_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (cnt_q == CNT_W'(PERIOD - 1))   cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.mul_src = SRC_D2;
    ctrl_o.add_op  = ADD_NONE;
    unique case (cnt_q)
      CNT_W'(0): begin ctrl_o.mul_issue = 1'b1; ctrl_o.mul_src = SRC_D2; ctrl_o.rom_idx = 3'd0; ctrl_o.x_load = 1'b1; end
      CNT_W'(1): ctrl_o.wr_r2 = 1'b1;
      CNT_W'(2): begin ctrl_o.mul_issue = 1'b1; ctrl_o.mul_src = SRC_D1; ctrl_o.rom_idx = 3'd1; end
      CNT_W'(3): ctrl_o.wr_r3 = 1'b1;
      CNT_W'(4): begin ctrl_o.mul_issue = 1'b1; ctrl_o.mul_src = SRC_D2; ctrl_o.rom_idx = 3'd2; ctrl_o.add_op = ADD_PSUM; end
      CNT_W'(5): begin ctrl_o.wr_r2 = 1'b1; ctrl_o.add_op = ADD_STATE; end
      CNT_W'(6): begin ctrl_o.mul_issue = 1'b1; ctrl_o.mul_src = SRC_D1; ctrl_o.rom_idx = 3'd3; end
      CNT_W'(7): ctrl_o.wr_r3 = 1'b1;
      CNT_W'(8): begin ctrl_o.mul_issue = 1'b1; ctrl_o.mul_src = SRC_W; ctrl_o.rom_idx = 3'd4; ctrl_o.add_op = ADD_PSUM; end
      CNT_W'(9): ctrl_o.wr_r2 = 1'b1;
      CNT_W'(10): begin ctrl_o.add_op = ADD_OUT; ctrl_o.shift = 1'b1; end
      default: ;
    endcase
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(PERIOD));
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.shift |=> ctrl_o.x_load);
endmodule

// File: rtl/biquad_coef_rom.sv
module biquad_coef_rom #(
  parameter int unsigned CW = 16,
  parameter logic signed [CW-1:0] A1 = '0,
  parameter logic signed [CW-1:0] A2 = '0,
  parameter logic signed [CW-1:0] B0 = '0,
  parameter logic signed [CW-1:0] B1 = '0,
  parameter logic signed [CW-1:0] B2 = '0
) (
  input  logic [2:0]           idx_i,
  output logic signed [CW-1:0] coef_o
);
  // order follows the multiply issue order
  always_comb begin
    unique case (idx_i)
      3'd0:    coef_o = A2;
      3'd1:    coef_o = A1;
      3'd2:    coef_o = B2;
      3'd3:    coef_o = B1;
      default: coef_o = B0;
    endcase
  end
endmodule

// File: rtl/biquad_mul2.sv
module biquad_mul2 #(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic signed [CW-1:0] coef_i,
  input  logic signed [DW-1:0] data_i,
  output logic signed [DW-1:0] prod_o
);
  localparam int unsigned PW = CW + DW;

  logic signed [CW-1:0] coef_q;
  logic signed [DW-1:0] data_q;
  logic signed [PW-1:0] full, shifted;

  // cycle 1: capture operands; cycle 2: product settles for the consumer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      data_q <= '0;
    end else if (issue_i) begin
      coef_q <= coef_i;
      data_q <= data_i;
    end
  end

  assign full    = PW'(coef_q) * PW'(data_q);
  assign shifted = full >>> FRAC;
  assign prod_o  = shifted[DW-1:0];

  assert_issue_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> !issue_i);
endmodule

// File: rtl/serial_biquad.sv
module serial_biquad
  import biquad_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 14,
  parameter logic signed [CW-1:0] COEF_A1 = 16'sd14746,
  parameter logic signed [CW-1:0] COEF_A2 = -16'sd6554,
  parameter logic signed [CW-1:0] COEF_B0 = 16'sd8192,
  parameter logic signed [CW-1:0] COEF_B1 = -16'sd16384,
  parameter logic signed [CW-1:0] COEF_B2 = 16'sd8192
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] sample_i,
  output logic signed [DW-1:0] y_o,
  output logic                 y_valid_o
);
  ctrl_t ctrl;
  logic signed [CW-1:0] coef;
  logic signed [DW-1:0] mul_in, prod;
  logic signed [DW-1:0] x_q, r1_q, r2_q, r3_q, r4_q, d0_q, d1_q, d2_q, y_q;
  logic signed [DW-1:0] add_a, add_b, sum;
  logic                 vld_q;

  biquad_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_o (ctrl)
  );

  biquad_coef_rom #(
    .CW(CW), .A1(COEF_A1), .A2(COEF_A2), .B0(COEF_B0), .B1(COEF_B1), .B2(COEF_B2)
  ) u_rom (
    .idx_i  (ctrl.rom_idx),
    .coef_o (coef)
  );

  always_comb begin
    unique case (ctrl.mul_src)
      SRC_D1:  mul_in = d1_q;
      SRC_W:   mul_in = r1_q;
      default: mul_in = d2_q;
    endcase
  end

  biquad_mul2 #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (ctrl.mul_issue),
    .coef_i  (coef),
    .data_i  (mul_in),
    .prod_o  (prod)
  );

  always_comb begin
    unique case (ctrl.add_op)
      ADD_STATE: begin add_a = x_q;  add_b = r4_q; end
      ADD_OUT:   begin add_a = r2_q; add_b = r4_q; end
      default:   begin add_a = r2_q; add_b = r3_q; end
    endcase
  end
  assign sum = add_a + add_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0; r1_q <= '0; r2_q <= '0; r3_q <= '0; r4_q <= '0;
      d0_q <= '0; d1_q <= '0; d2_q <= '0; y_q  <= '0; vld_q <= 1'b0;
    end else begin
      vld_q <= (ctrl.add_op == ADD_OUT);
      if (ctrl.x_load) x_q  <= sample_i;
      if (ctrl.wr_r2)  r2_q <= prod;
      if (ctrl.wr_r3)  r3_q <= prod;
      if (ctrl.add_op == ADD_PSUM) r4_q <= sum;
      if (ctrl.add_op == ADD_STATE) begin
        d0_q <= sum;
        r1_q <= sum;
      end
      if (ctrl.add_op == ADD_OUT) y_q <= sum;
      if (ctrl.shift) begin
        d1_q <= d0_q;
        d2_q <= d1_q;
      end
    end
  end

  assign y_o       = y_q;
  assign y_valid_o = vld_q;

  assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  assert_state_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.shift |=> $stable(d1_q) && $stable(d2_q));
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.add_op != ADD_OUT) |=> $stable(y_q));
  assert_w_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mul_issue && (ctrl.mul_src == SRC_W) |-> (r1_q == d0_q));
  assert_x_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.x_load |=> $stable(x_q));
endmodule

// File: tb/serial_biquad_tb_top.sv
`timescale 1ns/1ps
module serial_biquad_tb_top;
  localparam int DW = 16;
  localparam int FRAC = 14;
  localparam int CA1 = 14746, CA2 = -6554, CB0 = 8192, CB1 = -16384, CB2 = 8192;
  localparam int NSTIM = 24;
  // impulse, step, full-scale extremes
  localparam logic signed [15:0] STIM [NSTIM] = '{
    16'sd8192, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd4000, 16'sd4000, 16'sd4000, 16'sd4000, 16'sd4000, 16'sd4000, 16'sd4000, 16'sd4000,
    16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd0, -16'sd1, 16'sd1, -16'sd7, 16'sd123, 16'sd0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [DW-1:0] sample_i = '0;
  logic signed [DW-1:0] y_o;
  logic y_valid_o;
  int errors = 0, checks = 0;
  logic signed [15:0] m_d1 = '0, m_d2 = '0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_biquad dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .y_o(y_o), .y_valid_o(y_valid_o));

  function automatic logic signed [15:0] mulq(input int c, input int v);
    int p;
    p = c * v;
    p = p >>> FRAC;
    return p[15:0];
  endfunction

  function automatic logic signed [15:0] model_step(input logic signed [15:0] x);
    logic signed [15:0] s1, w, s2, y;
    s1 = mulq(CA2, int'(m_d2)) + mulq(CA1, int'(m_d1));
    w  = x + s1;
    s2 = mulq(CB2, int'(m_d2)) + mulq(CB1, int'(m_d1));
    y  = mulq(CB0, int'(w)) + s2;
    m_d2 = m_d1;
    m_d1 = w;
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(y_o == 0 && y_valid_o == 0, "R1 reset outputs", int'(y_o) + int'(y_valid_o), 0);
    rst_ni = 1'b1;
    m_d1 = '0;
    m_d2 = '0;
  endtask

  // starts at a negedge just before slot 0; returns at the negedge after the valid edge
  task automatic run_iter(input logic signed [15:0] x, input string req, output logic signed [15:0] got);
    logic signed [15:0] exp, prev;
    bit side_ok;
    exp = model_step(x);
    prev = y_o;
    side_ok = 1;
    sample_i = x;
    for (int k = 1; k <= 11; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) sample_i = ~x;          // R7: later values must be ignored
      else sample_i = sample_i + 16'sd371;
      if (k < 11 && (y_valid_o !== 1'b0 || y_o !== prev)) side_ok = 0;
    end
    check(side_ok, "R8 output held and strobe low mid-iteration", int'(y_o), int'(prev));
    check(y_valid_o === 1'b1, "R2 strobe after slot 10", int'(y_valid_o), 1);
    check(y_o === exp, req, int'(y_o), int'(exp));
    got = y_o;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic signed [15:0] got;
    int lo_peak, hi_peak, v;
    apply_reset();

    // table: R4 R5 R6 R7 R9 against the model; impulse tail exposes the slot-10 collision
    for (int i = 0; i < NSTIM; i++) run_iter(STIM[i], "R5 output vs model (R4 R6 R9)", got);

    // strobe drops again one clock later
    @(posedge clk); @(negedge clk);
    check(y_valid_o === 1'b0, "R2 strobe one cycle wide", int'(y_valid_o), 0);
    sample_i = '0;
    repeat (9) begin @(posedge clk); @(negedge clk); end
    void'(model_step(16'sd0));
    @(posedge clk); @(negedge clk);
    check(y_valid_o === 1'b1, "R2 period of 11", int'(y_valid_o), 1);

    // reset in mid-iteration, then R1 first output and R3 floor truncation
    @(negedge clk);
    sample_i = 16'sd500;
    repeat (5) @(posedge clk);
    apply_reset();
    run_iter(-16'sd3, "R1 R3 first output mulq(b0,-3)", got);
    check(got == -16'sd2, "R3 floor of negative product", int'(got), -2);

    // R10 high-pass: low tone
    apply_reset();
    lo_peak = 0;
    for (int n = 0; n < 64; n++) begin
      v = $rtoi(6000.0 * $sin(2.0 * 3.14159265358979 * n / 64.0));
      run_iter(16'(v), "R5 low tone vs model", got);
      if (n >= 32 && (got < 0 ? -int'(got) : int'(got)) > lo_peak) lo_peak = got < 0 ? -int'(got) : int'(got);
    end
    apply_reset();
    hi_peak = 0;
    for (int n = 0; n < 32; n++) begin
      v = (n % 4 == 1) ? 6000 : (n % 4 == 3) ? -6000 : 0;
      run_iter(16'(v), "R5 high tone vs model", got);
      if (n >= 16 && (got < 0 ? -int'(got) : int'(got)) > hi_peak) hi_peak = got < 0 ? -int'(got) : int'(got);
    end
    check(lo_peak * 8 <= hi_peak && hi_peak > 0, "R10 low tone attenuated", lo_peak, hi_peak);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule